// File: doc/BRIEF.md
# Flash erase and write controller

This block sits between the special-function-register bus of a small 8-bit microcontroller and a simple on-chip flash macro of 64 KB, organised as 128 pages of 512 bytes. Software starts an erase by writing a fixed byte pattern to a single command register. One pattern erases one page, chosen by a page-address register. The other pattern erases the whole array. It only works after software has armed it in the control register, and only while the debug port is enabled. A busy flag stays high from the moment a command is accepted until the flash macro reports that it is done.

The block also decides where each CPU external-data store goes. When the control register's program-write enable is set, a store becomes a one-cycle flash write strobe, carrying the store's 16-bit address and data byte. Otherwise the store goes to data RAM as usual. The enable cannot be set while interrupts are globally enabled.

Top module: `flashSeq`

## Requirements
- R1: After reset, busy, the erase request, the flash write strobe and the RAM write strobe are low, and the control value reads 0x00.
- R2: A write to SFR 0xB2 loads bit 0 (mass-erase arm) and bit 1 (program-write enable), which appear on ctlValue from the next cycle. All other bits of ctlValue read 0.
- R3: A write to 0xB2 that would set the program-write enable while intEnable is high leaves it cleared. Clearing it is always accepted.
- R4: When busy is low, writing 0x55 to SFR 0x94 starts a page erase. In the next cycle, flashEraseReq is high for exactly one cycle, flashMass is 0, and flashAddr is {P[7:1], 9'b0}, where P is the last byte written to SFR 0xB7. Bit 0 of P has no effect.
- R5: When busy is low, the arm bit is set and debugEn is high, writing 0xAA to 0x94 starts a mass erase. The next cycle shows a one-cycle flashEraseReq with flashMass 1 and flashAddr 0x0000.
- R6: A 0xAA write with busy low but with the arm bit clear or debugEn low starts nothing, and it clears the arm bit.
- R7: A write to 0x94 of any value other than 0xAA or 0x55 starts nothing and leaves ctlValue unchanged.
- R8: busy rises together with flashEraseReq. It stays high until the cycle after flashDone is sampled high. While busy is high, writes to 0x94 start nothing.
- R9: When a mass erase completes, the arm bit clears together with busy.
- R10: When storeEn is high and program-write enable is clear, ramWrite is high in the same cycle and flashWrite is low.
- R11: When storeEn is high, program-write enable is set and busy is low, flashWrite is high in the same cycle, with flashAddr = storeAddr and flashWrData = storeData, and ramWrite is low. If busy is high instead, neither strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sfrWrEn | input | 1 | SFR write strobe |
| sfrAddr | input | 8 | SFR address |
| sfrWrData | input | 8 | SFR write data |
| debugEn | input | 1 | Debug port enabled |
| intEnable | input | 1 | Global interrupt enable is active |
| storeEn | input | 1 | CPU external-data store cycle |
| storeAddr | input | 16 | Store address |
| storeData | input | 8 | Store data byte |
| flashDone | input | 1 | Flash macro finished the erase |
| flashEraseReq | output | 1 | One-cycle erase start pulse |
| flashMass | output | 1 | Erase is a mass erase |
| flashAddr | output | 16 | Erase base address or write address |
| flashWrData | output | 8 | Flash write byte |
| flashWrite | output | 1 | Flash write strobe |
| ramWrite | output | 1 | Data RAM write strobe |
| busy | output | 1 | An erase is in progress |
| ctlValue | output | 8 | Current control register value |

## Verification
Page erases are tried with page bytes that differ only in bit 0, to show that bit is dropped, and with the top and bottom pages, to show how the address is formed. Mass erase is tried with each precondition missing in turn, and then with all of them met. This separates a bad gate from a missing auto-clear of the arm bit. Stray command bytes, and valid patterns sent while busy, show that commands are ignored when they should be. Stores are issued with the program-write enable clear, set, and set during an erase, which shows the steering in all three states.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;
  typedef struct packed {
    logic loadPage;
    logic startPage;
    logic startMass;
    logic flashWr;
  } seqStrobes_t;
endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int SFR_W = 8,
  parameter logic [7:0] CMD_ADDR = 8'h94,
  parameter logic [7:0] PAGE_ADDR = 8'hB7,
  parameter logic [7:0] CTL_ADDR = 8'hB2,
  parameter logic [SFR_W-1:0] MASS_PAT = 8'hAA,
  parameter logic [SFR_W-1:0] PAGE_PAT = 8'h55
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sfrWrEn,
  input  logic [7:0]       sfrAddr,
  input  logic [SFR_W-1:0] sfrWrData,
  input  logic             debugEn,
  input  logic             intEnable,
  input  logic             storeEn,
  input  logic             flashDone,
  output seqStrobes_t      strobes,
  output logic             busy,
  output logic             ramWrite,
  output logic [SFR_W-1:0] ctlValue
);
  localparam int ARM_BIT = 0;
  localparam int PWE_BIT = 1;

  logic armReg, pweReg, massPending;
  logic cmdWr, ctlWr, massHit, massOk, pageOk, doneNow;

  assign cmdWr   = sfrWrEn && (sfrAddr == CMD_ADDR);
  assign ctlWr   = sfrWrEn && (sfrAddr == CTL_ADDR);
  assign massHit = cmdWr && !busy && (sfrWrData == MASS_PAT);
  assign massOk  = massHit && armReg && debugEn;
  assign pageOk  = cmdWr && !busy && (sfrWrData == PAGE_PAT);
  assign doneNow = busy && flashDone;

  always_comb begin
    strobes.loadPage  = sfrWrEn && (sfrAddr == PAGE_ADDR);
    strobes.startPage = pageOk;
    strobes.startMass = massOk;
    strobes.flashWr   = storeEn && pweReg && !busy;
    ramWrite          = storeEn && !pweReg;
    ctlValue          = '0;
    ctlValue[ARM_BIT] = armReg;
    ctlValue[PWE_BIT] = pweReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      massPending <= 1'b0;
    end else if (pageOk || massOk) begin
      busy        <= 1'b1;
      massPending <= massOk;
    end else if (doneNow) begin
      busy        <= 1'b0;
      massPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armReg <= 1'b0;
      pweReg <= 1'b0;
    end else begin
      if (ctlWr) begin
        armReg <= sfrWrData[ARM_BIT];
        pweReg <= sfrWrData[PWE_BIT] && (!intEnable || pweReg);
      end
      if ((massHit && !massOk) || (doneNow && massPending))
        armReg <= 1'b0;
    end
  end

  // R3: enable only appears if interrupts were off at the write
  assert_pwe_needs_int_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pweReg) |-> $past(!intEnable));
  // R8: busy holds until done is seen
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !flashDone) |=> busy);
  // R9: mass completion drops arm
  assert_arm_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && flashDone && massPending && !ctlWr) |=> !armReg);
endmodule

// File: rtl/flashSeqData.sv
module flashSeqData
  import flashSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_BITS = 9,
  parameter int DATA_W = 8,
  localparam int PG_W = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [PG_W-1:0]   pageField,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [DATA_W-1:0] storeData,
  output logic              flashEraseReq,
  output logic              flashMass,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashWrData,
  output logic              flashWrite
);
  logic [PG_W-1:0]   pageReg;
  logic [ADDR_W-1:0] eraseAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg       <= '0;
      eraseAddr     <= '0;
      flashEraseReq <= 1'b0;
      flashMass     <= 1'b0;
    end else begin
      if (strobes.loadPage) pageReg <= pageField;
      flashEraseReq <= strobes.startPage || strobes.startMass;
      if (strobes.startPage) begin
        flashMass <= 1'b0;
        eraseAddr <= {pageReg, {PAGE_BITS{1'b0}}};
      end else if (strobes.startMass) begin
        flashMass <= 1'b1;
        eraseAddr <= '0;
      end
    end
  end

  assign flashWrite  = strobes.flashWr;
  assign flashWrData = storeData;
  assign flashAddr   = strobes.flashWr ? storeAddr : eraseAddr;

  // R4: page erase base is page aligned
  assert_page_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flashEraseReq && !flashMass && !flashWrite) |-> (flashAddr[PAGE_BITS-1:0] == '0));
  // R4: erase request lasts one cycle
  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    flashEraseReq |=> !flashEraseReq);
endmodule

// File: rtl/flashSeq.sv
module flashSeq
  import flashSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_BITS = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWrEn,
  input  logic [7:0]        sfrAddr,
  input  logic [DATA_W-1:0] sfrWrData,
  input  logic              debugEn,
  input  logic              intEnable,
  input  logic              storeEn,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [DATA_W-1:0] storeData,
  input  logic              flashDone,
  output logic              flashEraseReq,
  output logic              flashMass,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashWrData,
  output logic              flashWrite,
  output logic              ramWrite,
  output logic              busy,
  output logic [DATA_W-1:0] ctlValue
);
  localparam int PG_W = ADDR_W - PAGE_BITS;
  seqStrobes_t strobes;

  flashSeqCtrl #(.SFR_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .debugEn(debugEn), .intEnable(intEnable),
    .storeEn(storeEn), .flashDone(flashDone), .strobes(strobes),
    .busy(busy), .ramWrite(ramWrite), .ctlValue(ctlValue)
  );

  flashSeqData #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pageField(sfrWrData[DATA_W-1 -: PG_W]), .storeAddr(storeAddr),
    .storeData(storeData), .flashEraseReq(flashEraseReq), .flashMass(flashMass),
    .flashAddr(flashAddr), .flashWrData(flashWrData), .flashWrite(flashWrite)
  );

  // R5: mass erase only with debug port on
  assert_mass_needs_debug_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flashEraseReq && flashMass) |-> $past(debugEn));
  // R8: erase pulse and busy rise together
  assert_busy_with_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> flashEraseReq);
  // R11: never both store targets
  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(flashWrite && ramWrite));
endmodule

// File: tb/sim_flashSeq.sv
module sim_flashSeq;
  logic clk = 0, rstN = 0;
  logic sfrWrEn = 0, debugEn = 0, intEnable = 0, storeEn = 0, flashDone = 0;
  logic [7:0] sfrAddr = 0, sfrWrData = 0, storeData = 0;
  logic [15:0] storeAddr = 0;
  logic flashEraseReq, flashMass, flashWrite, ramWrite, busy;
  logic [15:0] flashAddr;
  logic [7:0] flashWrData, ctlValue;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  flashSeq u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfrWrEn = 1; sfrAddr = a; sfrWrData = d;
    @(negedge clk); sfrWrEn = 0;
  endtask

  task automatic finishErase();
    @(negedge clk); flashDone = 1;
    @(negedge clk); flashDone = 0;
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0); chk("R1 req", flashEraseReq, 0);
    chk("R1 fw", flashWrite, 0); chk("R1 rw", ramWrite, 0); chk("R1 ctl", ctlValue, 0);
  endtask

  task automatic testCtl();
    sfrWrite(8'hB2, 8'hFF);
    chk("R2 ctl all", ctlValue, 8'h03);
    sfrWrite(8'hB2, 8'h00);
    chk("R2 ctl clr", ctlValue, 8'h00);
    intEnable = 1;
    sfrWrite(8'hB2, 8'h02);
    chk("R3 refused", ctlValue, 8'h00);
    intEnable = 0;
    sfrWrite(8'hB2, 8'h02);
    chk("R3 set", ctlValue, 8'h02);
    intEnable = 1;
    sfrWrite(8'hB2, 8'h00);
    chk("R3 clear ok", ctlValue, 8'h00);
    intEnable = 0;
  endtask

  task automatic pageCase(input logic [7:0] p);
    sfrWrite(8'hB7, p);
    sfrWrite(8'h94, 8'h55);
    chk("R4 req", flashEraseReq, 1); chk("R4 mass", flashMass, 0);
    chk("R4 addr", flashAddr, {p[7:1], 9'b0}); chk("R8 busy", busy, 1);
    @(negedge clk);
    chk("R4 one cycle", flashEraseReq, 0); chk("R8 hold", busy, 1);
    finishErase();
    chk("R8 clear", busy, 0);
  endtask

  task automatic testPage();
    pageCase(8'h0A); pageCase(8'h0B); pageCase(8'hFF); pageCase(8'h00);
  endtask

  task automatic testMassReject();
    debugEn = 0;
    sfrWrite(8'hB2, 8'h01);
    sfrWrite(8'h94, 8'hAA);
    chk("R6 no debug", flashEraseReq, 0); chk("R6 arm cleared", ctlValue, 0);
    debugEn = 1;
    sfrWrite(8'h94, 8'hAA);
    chk("R6 unarmed", flashEraseReq, 0); chk("R6 busy", busy, 0);
  endtask

  task automatic testMass();
    debugEn = 1;
    sfrWrite(8'hB7, 8'h42);
    sfrWrite(8'hB2, 8'h01);
    sfrWrite(8'h94, 8'hAA);
    chk("R5 req", flashEraseReq, 1); chk("R5 mass", flashMass, 1);
    chk("R5 addr", flashAddr, 0); chk("R5 busy", busy, 1);
    sfrWrite(8'h94, 8'h55);
    chk("R8 ignored busy", flashEraseReq, 0);
    chk("R9 armed during", ctlValue, 8'h01);
    finishErase();
    chk("R9 busy off", busy, 0); chk("R9 arm off", ctlValue, 0);
    debugEn = 0;
  endtask

  task automatic testStray();
    sfrWrite(8'hB2, 8'h01);
    sfrWrite(8'h94, 8'h5A);
    chk("R7 no req", flashEraseReq, 0); chk("R7 busy", busy, 0);
    chk("R7 ctl kept", ctlValue, 8'h01);
    sfrWrite(8'h94, 8'h00);
    chk("R7 zero", flashEraseReq, 0);
    sfrWrite(8'hB2, 8'h00);
  endtask

  task automatic testStore();
    @(negedge clk); storeEn = 1; storeAddr = 16'h1234; storeData = 8'h5C; #1;
    chk("R10 ram", ramWrite, 1); chk("R10 no flash", flashWrite, 0);
    @(negedge clk); storeEn = 0;
    sfrWrite(8'hB2, 8'h02);
    @(negedge clk); storeEn = 1; storeAddr = 16'hBEEF; storeData = 8'hA7; #1;
    chk("R11 flash", flashWrite, 1); chk("R11 no ram", ramWrite, 0);
    chk("R11 addr", flashAddr, 16'hBEEF); chk("R11 data", flashWrData, 8'hA7);
    @(negedge clk); storeEn = 0;
    sfrWrite(8'hB7, 8'h10);
    sfrWrite(8'h94, 8'h55);
    @(negedge clk); storeEn = 1; #1;
    chk("R11 busy no flash", flashWrite, 0); chk("R11 busy no ram", ramWrite, 0);
    chk("R4 addr kept", flashAddr, 16'h1000);
    @(negedge clk); storeEn = 0;
    finishErase();
    sfrWrite(8'hB2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testCtl();
    testPage();
    testMassReject();
    testMass();
    testStray();
    testStore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule